// File: doc/BRIEF.md
# Energy-Efficient Ethernet Low-Power-Idle Controller

This block decides when the transmit side of an Ethernet MAC may put its PHY into low-power idle (LPI), and when it must bring the link back to normal operation. It also records LPI transitions seen on the receive path. Software programs two timers and three control bits. The first timer is a link hold time, counted in milliseconds. The link-good bit must have been held for that long before LPI may be signalled. The second timer is a wake time, counted in microseconds. After LPI is withdrawn, transmission must stay held off for that long.

An external timebase supplies single-cycle millisecond and microsecond ticks. The MAC reports when its transmit path is idle, and the PHY side reports when the receive side is in LPI. Four sticky event flags capture transmit entry, transmit exit, receive entry and receive exit. A combined interrupt is raised while any flag is set. Reading the status word returns the flags and clears them.

Top module: `eee_lpi_ctrl`

## Requirements
- R1: After reset, txLpi, txWake and lpiIrq are low, and both register words read as zero.
- R2: The timer word (regAddr=1) holds the wake time in bits 15:0 (microsecond ticks) and the link hold time in bits 26:16 (millisecond ticks). It reads back exactly what was written, and bits 31:27 read as 0.
- R3: txLpi rises only when all of the following are true: the LPI enable (status word bit 16) is set, the link-good bit (bit 18) is set, txIdle is high, and at least the programmed number of millisecond ticks has arrived since link-good last went high.
- R4: Clearing link-good restarts the hold count from zero. If this happens during LPI, txLpi drops and the wake phase starts.
- R5: Clearing the LPI enable during LPI drops txLpi and starts the wake phase.
- R6: When auto-exit (bit 17) is set, txIdle going low during LPI starts the wake phase. When auto-exit is clear, txIdle going low has no effect on txLpi.
- R7: In the wake phase, txWake is high and txLpi is low. The wake phase ends after the programmed number of microsecond ticks. txLpi and txWake are never both high.
- R8: Status bit 0 sets when transmit enters LPI. Bit 1 sets when the wake phase ends. Bit 2 sets when rxLpi rises. Bit 3 sets when rxLpi falls. lpiIrq is high while any of these bits is set.
- R9: A read of the status word (regAddr=0) returns the flags and clears them. An event that occurs in the same cycle as the read is kept for the next read.
- R10: Control bits 16 (LPI enable), 17 (auto-exit) and 18 (link-good) are written at regAddr=0 and read back at the same positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe; a read of the status word clears the flags |
| regAddr | input | 1 | 0 selects status/control, 1 selects timers |
| regWData | input | 32 | Write data |
| regRData | output | 32 | Read data, combinational on regAddr |
| txIdle | input | 1 | Transmit path has nothing to send |
| rxLpi | input | 1 | Receive side is in LPI |
| msTick | input | 1 | One-cycle millisecond tick |
| usTick | input | 1 | One-cycle microsecond tick |
| txLpi | output | 1 | Signal LPI on the transmit side |
| txWake | output | 1 | Wake phase in progress; transmit held off |
| lpiIrq | output | 1 | Any event flag set |

## Verification
A status read and a new event can fall in the same clock edge. The flag register then has to clear and set in the same cycle. The bench provokes this by raising rxLpi in the same cycle as a status read. It then checks two things: the read returns the receive-entry bit still clear, and the next read returns it set. Transmit-path checks line up the tick pulses and control writes with the state changes, so that txLpi and txWake are sampled only after the state register has had time to settle.

// File: rtl/eee_lpi_pkg.sv
package eee_lpi_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT_LINK, ST_LPI, ST_WAKE} txState_t;

  typedef struct packed {
    logic enterEvt;
    logic exitEvt;
    logic wakeStart;
  } lpiStrobe_t;

  localparam int FLAG_TX_ENTER = 0;
  localparam int FLAG_TX_EXIT  = 1;
  localparam int FLAG_RX_ENTER = 2;
  localparam int FLAG_RX_EXIT  = 3;
  localparam int NUM_FLAGS     = 4;

  localparam int CTRL_EN_BIT   = 16;
  localparam int CTRL_AUTO_BIT = 17;
  localparam int CTRL_LINK_BIT = 18;

  localparam int TW_LSB = 0;
  localparam int LS_LSB = 16;
endpackage

// File: rtl/eee_lpi_fsm.sv
module eee_lpi_fsm
  import eee_lpi_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       lpiEn,
  input  logic       autoTx,
  input  logic       linkGood,
  input  logic       txIdle,
  input  logic       lsDone,
  input  logic       twDone,
  output lpiStrobe_t strobe,
  output logic       txLpi,
  output logic       txWake
);
  txState_t state, nextState;

  always_comb begin
    nextState = state;
    strobe    = '0;
    case (state)
      ST_IDLE:
        if (lpiEn && linkGood) nextState = ST_WAIT_LINK;
      ST_WAIT_LINK:
        if (!lpiEn || !linkGood) nextState = ST_IDLE;
        else if (lsDone && txIdle) begin
          nextState       = ST_LPI;
          strobe.enterEvt = 1'b1;
        end
      ST_LPI:
        if (!lpiEn || !linkGood || (autoTx && !txIdle)) begin
          nextState        = ST_WAKE;
          strobe.wakeStart = 1'b1;
        end
      ST_WAKE:
        if (twDone) begin
          nextState      = ST_IDLE;
          strobe.exitEvt = 1'b1;
        end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign txLpi  = (state == ST_LPI);
  assign txWake = (state == ST_WAKE);
endmodule

// File: rtl/eee_lpi_dp.sv
module eee_lpi_dp
  import eee_lpi_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LS_W   = 11,
  parameter int TW_W   = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWr,
  input  logic                 regRd,
  input  logic                 regAddr,
  input  logic [DATA_W-1:0]    regWData,
  output logic [DATA_W-1:0]    regRData,
  input  logic                 rxLpi,
  input  logic                 msTick,
  input  logic                 usTick,
  input  lpiStrobe_t           strobe,
  output logic                 lpiEn,
  output logic                 autoTx,
  output logic                 linkGood,
  output logic                 lsDone,
  output logic                 twDone,
  output logic                 lpiIrq,
  output logic                 rdClr,
  output logic [NUM_FLAGS-1:0] evtSet
);
  logic [LS_W-1:0]      lsCfg, lsCnt;
  logic [TW_W-1:0]      twCfg, twCnt;
  logic [NUM_FLAGS-1:0] flags;
  logic                 rxLpiQ;
  logic                 wrCtrl, wrTmr;
  logic                 unusedWrBits;

  assign wrCtrl = regWr && !regAddr;
  assign wrTmr  = regWr &&  regAddr;
  assign rdClr  = regRd && !regAddr;
  assign unusedWrBits = ^regWData;

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lpiEn    <= 1'b0;
      autoTx   <= 1'b0;
      linkGood <= 1'b0;
      lsCfg    <= '0;
      twCfg    <= '0;
    end else begin
      if (wrCtrl) begin
        lpiEn    <= regWData[CTRL_EN_BIT];
        autoTx   <= regWData[CTRL_AUTO_BIT];
        linkGood <= regWData[CTRL_LINK_BIT];
      end
      if (wrTmr) begin
        twCfg <= regWData[TW_LSB +: TW_W];
        lsCfg <= regWData[LS_LSB +: LS_W];
      end
    end
  end

  // link hold timer: restarts whenever link-good is low, saturates when done
  assign lsDone = (lsCnt >= lsCfg);
  always_ff @(posedge clk) begin
    if (!rstN || !linkGood)       lsCnt <= '0;
    else if (msTick && !lsDone)   lsCnt <= lsCnt + LS_W'(1);
  end

  // wake timer: cleared when the wake phase starts
  assign twDone = (twCnt >= twCfg);
  always_ff @(posedge clk) begin
    if (!rstN || strobe.wakeStart) twCnt <= '0;
    else if (usTick && !twDone)    twCnt <= twCnt + TW_W'(1);
  end

  // event flags: a new event wins over a clearing read
  always_comb begin
    evtSet                = '0;
    evtSet[FLAG_TX_ENTER] = strobe.enterEvt;
    evtSet[FLAG_TX_EXIT]  = strobe.exitEvt;
    evtSet[FLAG_RX_ENTER] = rxLpi && !rxLpiQ;
    evtSet[FLAG_RX_EXIT]  = !rxLpi && rxLpiQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flags  <= '0;
      rxLpiQ <= 1'b0;
    end else begin
      rxLpiQ <= rxLpi;
      flags  <= (flags & ~{NUM_FLAGS{rdClr}}) | evtSet;
    end
  end

  assign lpiIrq = |flags;

  always_comb begin
    regRData = '0;
    if (regAddr) begin
      regRData[TW_LSB +: TW_W] = twCfg;
      regRData[LS_LSB +: LS_W] = lsCfg;
    end else begin
      regRData[NUM_FLAGS-1:0] = flags;
      regRData[CTRL_EN_BIT]   = lpiEn;
      regRData[CTRL_AUTO_BIT] = autoTx;
      regRData[CTRL_LINK_BIT] = linkGood;
    end
  end
endmodule

// File: rtl/eee_lpi_ctrl.sv
module eee_lpi_ctrl
  import eee_lpi_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LS_W   = 11,
  parameter int TW_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWData,
  output logic [DATA_W-1:0] regRData,
  input  logic              txIdle,
  input  logic              rxLpi,
  input  logic              msTick,
  input  logic              usTick,
  output logic              txLpi,
  output logic              txWake,
  output logic              lpiIrq
);
  lpiStrobe_t           strobe;
  logic                 ctrlLpiEn, ctrlAuto, ctrlLink, lsDone, twDone, statRdClr;
  logic [NUM_FLAGS-1:0] evtSet;

  eee_lpi_fsm u_fsm (
    .clk(clk), .rstN(rstN), .lpiEn(ctrlLpiEn), .autoTx(ctrlAuto),
    .linkGood(ctrlLink), .txIdle(txIdle), .lsDone(lsDone), .twDone(twDone),
    .strobe(strobe), .txLpi(txLpi), .txWake(txWake)
  );

  eee_lpi_dp #(.DATA_W(DATA_W), .LS_W(LS_W), .TW_W(TW_W)) u_dp (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWData(regWData), .regRData(regRData), .rxLpi(rxLpi), .msTick(msTick),
    .usTick(usTick), .strobe(strobe), .lpiEn(ctrlLpiEn), .autoTx(ctrlAuto),
    .linkGood(ctrlLink), .lsDone(lsDone), .twDone(twDone), .lpiIrq(lpiIrq),
    .rdClr(statRdClr), .evtSet(evtSet)
  );
endmodule

// File: rtl/eee_lpi_chk.sv
module eee_lpi_chk (
  input logic       clk,
  input logic       rstN,
  input logic       txLpi,
  input logic       txWake,
  input logic       lpiIrq,
  input logic       lpiEn,
  input logic       linkGood,
  input logic       txIdle,
  input logic       rxLpi,
  input logic       rdClr,
  input logic [3:0] evtSet
);
  p_entry_gate_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txLpi) |-> $past(lpiEn && linkGood && txIdle));

  p_link_drop_r4: assert property (@(posedge clk) disable iff (!rstN)
    (txLpi && !linkGood) |=> (!txLpi && txWake));

  p_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(txLpi && txWake));

  p_exit_wake_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txLpi) |-> txWake);

  p_rx_event_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxLpi) |=> lpiIrq);

  p_read_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rdClr && evtSet == 4'b0) |=> !lpiIrq);
endmodule

bind eee_lpi_ctrl eee_lpi_chk u_chk (
  .clk(clk), .rstN(rstN), .txLpi(txLpi), .txWake(txWake), .lpiIrq(lpiIrq),
  .lpiEn(ctrlLpiEn), .linkGood(ctrlLink), .txIdle(txIdle), .rxLpi(rxLpi),
  .rdClr(statRdClr), .evtSet(evtSet)
);

// File: tb/sim_eee_lpi_ctrl.sv
`timescale 1ns/1ps
module sim_eee_lpi_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0, regRd = 1'b0, regAddr = 1'b0;
  logic [31:0] regWData = '0;
  logic [31:0] regRData;
  logic        txIdle = 1'b1, rxLpi = 1'b0, msTick = 1'b0, usTick = 1'b0;
  logic        txLpi, txWake, lpiIrq;
  int          nChecks = 0, nFail = 0;
  logic [31:0] rd;

  always #2.5 clk = ~clk;

  eee_lpi_ctrl u0 (.*);

  // {write value, expected readback} for the timer word (R2)
  localparam logic [63:0] TMR_VEC [5] = '{
    {32'hFFFF_FFFF, 32'h07FF_FFFF},
    {32'h0000_0000, 32'h0000_0000},
    {32'h8001_ABCD, 32'h0001_ABCD},
    {32'h07FF_0000, 32'h07FF_0000},
    {32'h0003_0002, 32'h0003_0002}
  };

  localparam logic [31:0] EN = 32'h1 << 16, AUTO = 32'h1 << 17, LINK = 32'h1 << 18;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrReg(input logic a, input logic [31:0] d);
    @(negedge clk); regWr = 1'b1; regAddr = a; regWData = d;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic rdReg(input logic a, output logic [31:0] d);
    @(negedge clk); regRd = 1'b1; regAddr = a;
    #1 d = regRData;
    @(negedge clk); regRd = 1'b0;
  endtask

  task automatic msPulse();
    @(negedge clk); msTick = 1'b1;
    @(negedge clk); msTick = 1'b0;
  endtask

  task automatic usPulse();
    @(negedge clk); usTick = 1'b1;
    @(negedge clk); usTick = 1'b0;
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    waitCyc(4);
    rstN = 1'b1;
    waitCyc(1);
    // R1 reset state
    chk("R1 outputs", {29'b0, txLpi, txWake, lpiIrq}, 32'h0);
    rdReg(1'b0, rd); chk("R1 status", rd, 32'h0);
    rdReg(1'b1, rd); chk("R1 timer", rd, 32'h0);

    // R2 timer word vectors
    foreach (TMR_VEC[i]) begin
      wrReg(1'b1, TMR_VEC[i][63:32]);
      rdReg(1'b1, rd);
      chk("R2 timer readback", rd, TMR_VEC[i][31:0]);
    end
    // now hold = 3 ms ticks, wake = 2 us ticks

    // R10 control readback, R3 entry after hold time
    wrReg(1'b0, EN | AUTO | LINK);
    rdReg(1'b0, rd); chk("R10 control readback", rd, EN | AUTO | LINK);
    msPulse(); msPulse(); waitCyc(3);
    chk("R3 no LPI before hold", {31'b0, txLpi}, 32'h0);
    msPulse(); waitCyc(2);
    chk("R3 LPI after hold", {31'b0, txLpi}, 32'h1);
    chk("R8 irq on tx enter", {31'b0, lpiIrq}, 32'h1);
    rdReg(1'b0, rd); chk("R8 tx enter flag", rd & 32'hF, 32'h1);
    rdReg(1'b0, rd); chk("R9 flags cleared", rd & 32'hF, 32'h0);

    // R6 auto-exit on new data, R7 wake length
    txIdle = 1'b0; waitCyc(2);
    chk("R6 auto exit to wake", {30'b0, txLpi, txWake}, 32'h1);
    usPulse(); waitCyc(2);
    chk("R7 wake held", {30'b0, txLpi, txWake}, 32'h1);
    usPulse(); waitCyc(2);
    chk("R7 wake done", {30'b0, txLpi, txWake}, 32'h0);
    rdReg(1'b0, rd); chk("R8 tx exit flag", rd & 32'hF, 32'h2);
    txIdle = 1'b1; waitCyc(3);
    chk("R3 re-entry when idle", {31'b0, txLpi}, 32'h1);
    rdReg(1'b0, rd);

    // R6 auto-exit off: txIdle ignored; R5 enable clear exits
    wrReg(1'b0, EN | LINK);
    txIdle = 1'b0; waitCyc(3);
    chk("R6 no exit without auto", {30'b0, txLpi, txWake}, 32'h2);
    wrReg(1'b0, LINK); waitCyc(1);
    chk("R5 enable clear to wake", {30'b0, txLpi, txWake}, 32'h1);
    usPulse(); usPulse(); waitCyc(2);
    txIdle = 1'b1;

    // R4 link drop during LPI
    wrReg(1'b0, EN | AUTO | LINK); waitCyc(3);
    chk("R4 LPI before drop", {31'b0, txLpi}, 32'h1);
    wrReg(1'b0, EN | AUTO); waitCyc(1);
    chk("R4 link drop to wake", {30'b0, txLpi, txWake}, 32'h1);
    usPulse(); usPulse(); waitCyc(2);
    wrReg(1'b0, EN | AUTO | LINK);
    msPulse(); msPulse(); waitCyc(3);
    chk("R4 hold count restarted", {31'b0, txLpi}, 32'h0);
    msPulse(); waitCyc(2);
    chk("R4 LPI after full hold", {31'b0, txLpi}, 32'h1);
    rdReg(1'b0, rd);

    // R8 receive events
    rxLpi = 1'b1; waitCyc(2);
    rdReg(1'b0, rd); chk("R8 rx enter flag", rd & 32'hF, 32'h4);
    rxLpi = 1'b0; waitCyc(2);
    rdReg(1'b0, rd); chk("R8 rx exit flag", rd & 32'hF, 32'h8);
    chk("R9 irq low after read", {31'b0, lpiIrq}, 32'h0);

    // R9 read coinciding with a new event
    @(negedge clk); regRd = 1'b1; regAddr = 1'b0; rxLpi = 1'b1;
    #1 rd = regRData;
    @(negedge clk); regRd = 1'b0;
    chk("R9 same-cycle read shows old", rd & 32'hF, 32'h0);
    rdReg(1'b0, rd); chk("R9 same-cycle event kept", rd & 32'hF, 32'h4);

    finishRun();
  end
endmodule